// File: doc/BRIEF.md
# Interrupt Cause and Mask Register File

This block collects interrupt events from up to `N_SRC` hardware sources and presents them to software through four registers on a simple 32-bit register bus. A one-cycle pulse on a source line latches a pending bit in the cause register. Software reads the pending set, clears bits by writing ones, and can inject causes for test by writing ones to a set register. Each source is enabled or disabled through a pair of registers: one write-one-to-set and one write-one-to-clear. No single register ever overwrites the whole mask.

A single registered request output is high whenever at least one pending cause is also enabled. The output can drive a wired interrupt line or a message-based interrupt generator. The bus side has a write strobe, a read strobe, a byte address and write data. Read data is registered and valid on the cycle after the read strobe.

Top module: `irq_cause_regs`

## Requirements
- R1: After reset, the cause bits are all zero, the mask bits are all zero (every source disabled), `irq_o` is low and `rdata_o` is zero.
- R2: The registers sit at these byte addresses: cause/clear at 0x0C0, cause-set at 0x0C8, mask-set at 0x0D0 and mask-clear at 0x0D8. Source k maps to data bit k, for k below `N_SRC`.
- R3: A high level on `event_i[k]` at a clock edge sets cause bit k. The bit stays set until software clears it.
- R4: A write to 0x0C0 clears every cause bit whose data bit is one. Cause bits written with zero keep their value.
- R5: A write to 0x0C8 sets every cause bit whose data bit is one. This raises `irq_o` only for bits whose mask bit is set.
- R6: A write to 0x0D0 sets every mask bit whose data bit is one. All other mask bits keep their value, and no other access changes the mask.
- R7: A write to 0x0D8 clears every mask bit whose data bit is one. All other mask bits keep their value.
- R8: `irq_o` equals the OR over all sources of (cause AND mask), taken from the register values one clock earlier.
- R9: When a hardware event and a software clear hit the same cause bit in the same cycle, the bit ends up set.
- R10: A read strobe captures data that `rdata_o` shows from the next cycle on. Address 0x0C0 returns the cause bits and 0x0D0 returns the mask bits. Addresses 0x0C8, 0x0D8 and all unmapped addresses return zero, and data bits at or above `N_SRC` always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| event_i | input | N_SRC | Hardware event pulses, one per source |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Writes and events update the cause and mask bits at the clock edge that samples them. Read data appears one edge after the read strobe. `irq_o` follows two edges after the stimulus, so a cause injected at edge E is visible on `irq_o` only after edge E+1.

The bench drives on falling edges and samples on falling edges. It checks `irq_o` both one falling edge after a write completes, where the old value must still hold, and one falling edge later, where the new value is due. A sweep covers every mask pattern of an 8-source build against a set of cause patterns. Read-back captures each register's value only after the access that changed it.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  localparam int unsigned CAUSE_OFS = 'h0C0;
  localparam int unsigned CSET_OFS  = 'h0C8;
  localparam int unsigned MSET_OFS  = 'h0D0;
  localparam int unsigned MCLR_OFS  = 'h0D8;

  typedef struct packed {
    logic cause_clr;
    logic cause_set;
    logic mask_set;
    logic mask_clr;
  } wr_sel_t;

  typedef enum logic [1:0] {
    RD_ZERO  = 2'd0,
    RD_CAUSE = 2'd1,
    RD_MASK  = 2'd2
  } rd_src_e;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_cause_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wr_sel_t           wr_sel_o,
  output rd_src_e           rd_src_o
);
  logic hit_cause, hit_cset, hit_mset, hit_mclr;

  assign hit_cause = (addr_i == ADDR_W'(CAUSE_OFS));
  assign hit_cset  = (addr_i == ADDR_W'(CSET_OFS));
  assign hit_mset  = (addr_i == ADDR_W'(MSET_OFS));
  assign hit_mclr  = (addr_i == ADDR_W'(MCLR_OFS));

  always_comb begin
    wr_sel_o.cause_clr = wr_en_i & hit_cause;
    wr_sel_o.cause_set = wr_en_i & hit_cset;
    wr_sel_o.mask_set  = wr_en_i & hit_mset;
    wr_sel_o.mask_clr  = wr_en_i & hit_mclr;
  end

  always_comb begin
    if (hit_cause)     rd_src_o = RD_CAUSE;
    else if (hit_mset) rd_src_o = RD_MASK;
    else               rd_src_o = RD_ZERO;
  end
endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_cause_pkg::*;
#(
  parameter int unsigned N_SRC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  wr_sel_t          wr_sel_i,
  input  logic [N_SRC-1:0] wbits_i,
  input  logic [N_SRC-1:0] event_i,
  output logic [N_SRC-1:0] cause_o,
  output logic [N_SRC-1:0] mask_o
);
  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    logic cause_q, mask_q;
    logic set_c, clr_c, set_m, clr_m;

    assign set_c = event_i[k] | (wr_sel_i.cause_set & wbits_i[k]);
    assign clr_c = wr_sel_i.cause_clr & wbits_i[k];
    assign set_m = wr_sel_i.mask_set & wbits_i[k];
    assign clr_m = wr_sel_i.mask_clr & wbits_i[k];

    // set beats clear so a fresh event is never lost
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    cause_q <= 1'b0;
      else if (set_c) cause_q <= 1'b1;
      else if (clr_c) cause_q <= 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    mask_q <= 1'b0;
      else if (set_m) mask_q <= 1'b1;
      else if (clr_m) mask_q <= 1'b0;
    end

    assign cause_o[k] = cause_q;
    assign mask_o[k]  = mask_q;
  end
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
  parameter int unsigned N_SRC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] cause_i,
  input  logic [N_SRC-1:0] mask_i,
  output logic             irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(cause_i & mask_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_cause_regs.sv
module irq_cause_regs
  import irq_cause_pkg::*;
#(
  parameter int unsigned N_SRC  = 16,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_SRC-1:0]  event_i,
  output logic              irq_o
);
  wr_sel_t          wr_sel;
  rd_src_e          rd_src;
  logic [N_SRC-1:0] cause_q, mask_q;
  logic [DATA_W-1:0] rd_mux, rdata_q;

  irq_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wr_sel_o(wr_sel),
    .rd_src_o(rd_src)
  );

  irq_src_bank #(.N_SRC(N_SRC)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_sel_i(wr_sel),
    .wbits_i (wdata_i[N_SRC-1:0]),
    .event_i (event_i),
    .cause_o (cause_q),
    .mask_o  (mask_q)
  );

  irq_req_gen #(.N_SRC(N_SRC)) u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cause_i(cause_q),
    .mask_i (mask_q),
    .irq_o  (irq_o)
  );

  always_comb begin
    unique case (rd_src)
      RD_CAUSE: rd_mux = DATA_W'(cause_q);
      RD_MASK:  rd_mux = DATA_W'(mask_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_cause_regs_chk.sv
module irq_cause_regs_chk
  import irq_cause_pkg::*;
#(
  parameter int unsigned N_SRC  = 16,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [N_SRC-1:0]  event_i,
  input logic [N_SRC-1:0]  cause_q,
  input logic [N_SRC-1:0]  mask_q,
  input logic              irq_o
);
  logic [N_SRC-1:0] wb;
  logic w_cclr, w_cset, w_mset, w_mclr;

  assign wb     = wdata_i[N_SRC-1:0];
  assign w_cclr = wr_en_i && (addr_i == ADDR_W'(CAUSE_OFS));
  assign w_cset = wr_en_i && (addr_i == ADDR_W'(CSET_OFS));
  assign w_mset = wr_en_i && (addr_i == ADDR_W'(MSET_OFS));
  assign w_mclr = wr_en_i && (addr_i == ADDR_W'(MCLR_OFS));

  AST_EVENT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|event_i) |=> ((cause_q & $past(event_i)) == $past(event_i))); // R3
  AST_CAUSE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_cclr |=> ((cause_q & $past(wb & ~event_i)) == '0)); // R4
  AST_CAUSE_INJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_cset |=> ((cause_q & $past(wb)) == $past(wb))); // R5
  AST_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_mset |=> ((mask_q & $past(wb)) == $past(wb))); // R6
  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(w_mset || w_mclr) |=> $stable(mask_q)); // R6
  AST_MASK_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_mclr |=> ((mask_q & $past(wb)) == '0)); // R7
  AST_IRQ_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(cause_q & mask_q)))); // R8
  AST_EVENT_OVER_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_cclr && |(event_i & wb)) |=> ((cause_q & $past(event_i & wb)) == $past(event_i & wb))); // R9
endmodule

bind irq_cause_regs irq_cause_regs_chk #(
  .N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_en_i(wr_en_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .event_i(event_i),
  .cause_q(cause_q),
  .mask_q (mask_q),
  .irq_o  (irq_o)
);

// File: tb/irq_cause_regs_tb_top.sv
module irq_cause_regs_tb_top;
  localparam int unsigned NS = 8;
  localparam int unsigned AW = 12;
  localparam int unsigned DW = 32;
  localparam logic [AW-1:0] A_CAUSE = 12'h0C0;
  localparam logic [AW-1:0] A_CSET  = 12'h0C8;
  localparam logic [AW-1:0] A_MSET  = 12'h0D0;
  localparam logic [AW-1:0] A_MCLR  = 12'h0D8;

  logic          clk, rst_n, wr_en, rd_en, irq;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic [NS-1:0] ev;
  int n_cmp = 0;
  int n_err = 0;
  bit done = 0;

  irq_cause_regs #(.N_SRC(NS), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .event_i(ev), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic do_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc >= 200000) begin
        n_cmp++; n_err++;
        $display("FAIL watchdog actual=%0d expected=<200000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    logic [DW-1:0] rv;
    logic [NS-1:0] pats [9];
    pats[0] = 8'h00; pats[1] = 8'h01; pats[2] = 8'h80; pats[3] = 8'h55;
    pats[4] = 8'hAA; pats[5] = 8'h0F; pats[6] = 8'hF0; pats[7] = 8'hFF;
    pats[8] = 8'h18;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; ev = '0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk("R1 irq", DW'(irq), '0);
    chk("R1 rdata", rdata, '0);
    rst_n = 1'b1;
    do_rd(A_CAUSE, rv); chk("R1 cause", rv, '0);
    do_rd(A_MSET, rv);  chk("R1 mask", rv, '0);

    // R2 R5 R6 R8: sweep every mask pattern against cause patterns
    for (int m = 0; m < 256; m++) begin
      do_wr(A_MCLR, 32'hFFFF_FFFF);
      do_wr(A_MSET, DW'(m));
      do_rd(A_MSET, rv); chk("R6 mask readback", rv, DW'(m));
      for (int p = 0; p < 9; p++) begin
        logic exp_irq;
        do_wr(A_CAUSE, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R4 irq low after clear", DW'(irq), '0);
        do_wr(A_CSET, {24'hFFFFFF, pats[p]});
        exp_irq = |(pats[p] & NS'(m));
        chk("R8 irq not yet", DW'(irq), '0);
        @(negedge clk);
        chk("R5 R8 irq", DW'(irq), DW'(exp_irq));
        if (p == 3 || p == 7) begin
          do_rd(A_CAUSE, rv); chk("R5 R10 cause", rv, DW'(pats[p]));
        end
      end
    end

    // R7: partial mask clear
    do_wr(A_MCLR, 32'hFF); do_wr(A_MSET, 32'hF3);
    do_wr(A_MCLR, 32'h21);
    do_rd(A_MSET, rv); chk("R7 partial clear", rv, 32'hD2);
    do_wr(A_MCLR, 32'h00);
    do_rd(A_MSET, rv); chk("R7 zero write no effect", rv, 32'hD2);
    do_wr(A_CSET, 32'h00); do_wr(A_CAUSE, 32'h00);
    do_rd(A_MSET, rv); chk("R6 cause writes leave mask", rv, 32'hD2);

    // R4: partial cause clear
    do_wr(A_CAUSE, 32'hFF); do_wr(A_CSET, 32'h3C);
    do_wr(A_CAUSE, 32'h24);
    do_rd(A_CAUSE, rv); chk("R4 partial clear", rv, 32'h18);

    // R3: hardware event pulse latches and holds
    do_wr(A_CAUSE, 32'hFF);
    do_wr(A_MCLR, 32'hFF);
    @(negedge clk); ev = 8'h41;
    @(negedge clk); ev = '0;
    repeat (3) @(negedge clk);
    do_rd(A_CAUSE, rv); chk("R3 event latched", rv, 32'h41);
    chk("R8 masked event no irq", DW'(irq), '0);
    do_wr(A_MSET, 32'h40);
    @(negedge clk);
    chk("R8 irq after enable", DW'(irq), 32'h1);

    // R9: event and software clear on the same bit in the same cycle
    @(negedge clk);
    wr_en = 1'b1; addr = A_CAUSE; wdata = 32'hFF; ev = 8'h08;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0; ev = '0;
    do_rd(A_CAUSE, rv); chk("R9 event wins", rv, 32'h08);

    // R10: zero-reading and unmapped offsets
    do_wr(A_MSET, 32'hFF); do_wr(A_CSET, 32'hFF);
    do_rd(A_MCLR, rv);   chk("R10 mask-clear reads 0", rv, '0);
    do_rd(A_CSET, rv);   chk("R10 cause-set reads 0", rv, '0);
    do_rd(12'h000, rv);  chk("R10 unmapped reads 0", rv, '0);
    do_rd(12'h0C4, rv);  chk("R10 near offset reads 0", rv, '0);
    do_rd(A_CAUSE, rv);  chk("R10 upper bits zero", rv, 32'hFF);
    // R2: write to unmapped offset changes nothing
    do_wr(12'h0E0, 32'h00);
    do_wr(12'h0D4, 32'hFF);
    do_rd(A_MSET, rv);   chk("R2 unmapped write ignored", rv, 32'hFF);

    done = 1;
    finish_run();
  end
endmodule